// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing half of a 16K x 8 serial memory. It runs on a system clock and oversamples the two bus lines, SCL and SDA. From the samples it finds start and stop conditions and the clock edges. It shifts bytes in and out, and it drives SDA low through an open-drain enable whenever it acknowledges a byte or sends a zero bit. It has no SDA output pin of its own. The bus wire is the AND of every driver, so the slave only ever pulls the line low.

Once the controller has accepted its device byte, it follows the transaction the master asks for. A write takes two word-address bytes and then any number of data bytes. Each data byte goes to a page write buffer through a strobe, and a commit pulse after the stop starts the internal write cycle. A read sends bytes taken from a memory read port, starting at the internal pointer. A random read is a write header that carries the word address, followed by a repeated start and a read header. While the memory reports an internal write in progress, the controller answers its own device byte with NACK. The master can poll on this until the write finishes.

The memory read port is combinational: `rdData` must show the byte at `rdAddr` in the same cycle. The controller captures it when `rdReq` is high.

Top module: `tws_eeprom_slave`

## Requirements
- R1: After reset the controller keeps SDA released (`sdaOe` low), and `wrStrobe` and `wrCommit` stay low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point releases SDA, drops any partial byte and waits for a fresh device byte. A byte cut short by a start produces no write and does not move the pointer.
- R3: The device byte is accepted only when bits 7:3 equal 10100 and bits 2:1 equal `strapAddr[1:0]`. Bit 0 selects the direction: 1 is read, 0 is write.
- R4: For every byte it accepts (device byte, both address bytes, data bytes), the slave pulls SDA low through the ninth clock of that byte.
- R5: A write carries a high and a low word-address byte. Bits 5:0 of the high byte become pointer bits 13:8, and its bits 7:6 are ignored. Each data byte then produces one `wrStrobe` with `wrAddr` equal to the pointer and `wrData` equal to the byte.
- R6: During a write the pointer's low 6 bits increment after each data byte and wrap from 63 to 0, while bits 13:6 stay fixed.
- R7: `wrCommit` pulses once after a stop if at least one data byte was accepted since the last start. A start discards that pending commit.
- R8: A random read returns the byte at the word address sent in the preceding write header, most significant bit first.
- R9: A read header with no word address returns the byte at the pointer. The pointer holds one past the last byte read, or the next in-page address after the last byte written.
- R10: Each master ACK after a read byte makes the slave send the byte at the next address. The address wraps from 16383 to 0.
- R11: After a master NACK the slave releases SDA and ignores further clocks until the next start.
- R12: While `busy` is high, the device byte gets no ACK, so a master that polls sees NACK until `busy` falls and ACK afterwards.
- R13: After a device byte that does not match, the slave keeps SDA released and ignores all following bytes until the next start.
- R14: The slave changes `sdaOe` only while SCL is low, one system clock after it detects the falling SCL edge. Its output bits are therefore steady across each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| strapAddr | input | 2 | Board-strapped device address bits |
| busy | input | 1 | Internal write cycle in progress |
| rdAddr | output | 14 | Memory read address (the pointer) |
| rdReq | output | 1 | Read capture strobe for `rdData` |
| rdData | input | 8 | Byte at `rdAddr`, valid in the same cycle |
| wrStrobe | output | 1 | Page buffer write strobe |
| wrAddr | output | 14 | Page buffer address for the strobed byte |
| wrData | output | 8 | Page buffer data for the strobed byte |
| wrCommit | output | 1 | Start the internal write cycle |

## Verification
The bench sweeps every strap value against every address field, so a swapped or misaligned strap compare shows up as a missing or extra ACK. It writes more than a full page starting near the top of a page. A pointer that carried into bit 6 would show up as a wrong `wrAddr` on the strobes past the wrap, and a wrong pointer after the wrap would show up on the current-address read that follows. A sequential read that crosses address 16383 catches a pointer that saturates or keeps stale high bits. A first address byte with its top bits set catches a controller that lets those bits through. Three further cases are covered. A start in the middle of a data byte, and a start after an accepted data byte, would show a design that writes a partial byte or commits at the wrong time. Polling during a busy write catches an ACK given too early. Clocks sent after a master NACK would reveal a slave that keeps driving the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WHI,
    ST_WLO,
    ST_WDAT,
    ST_SEND
  } ctlState_t;

  // One-cycle requests from the sequencer to the datapath
  typedef struct packed {
    logic sampleBit;   // shift the sampled SDA level into the receive register
    logic ackDrive;    // pull SDA low for the acknowledge slot
    logic sdaFree;     // let go of SDA
    logic loadTx;      // capture a read byte, drive its MSB, advance pointer
    logic shiftTx;     // drive the next transmit bit
    logic setAddrHi;   // load upper pointer bits from received byte
    logic setAddrLo;   // load lower pointer bits from received byte
    logic writeByte;   // hand received byte to the page buffer
  } strobe_t;

endpackage

// File: rtl/tws_line_sampler.sv
module tws_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic sdaBit
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          sclLast;
  logic          sdaLast;
  logic          sclNow;
  logic          sdaNow;

  assign sclNow = sclPipe[LAST];
  assign sdaNow = sdaPipe[LAST];

  // Idle bus reads high, so the pipeline resets high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclLast <= sclNow;
      sdaLast <= sdaNow;
    end
  end

  assign sclRise  = sclNow & ~sclLast;
  assign sclFall  = ~sclNow & sclLast;
  assign startDet = sclNow & sclLast & sdaLast & ~sdaNow;
  assign stopDet  = sclNow & sclLast & ~sdaLast & sdaNow;
  assign sdaBit   = sdaNow;

endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
#(
  parameter int                 STRAP_W  = 2,
  parameter logic [6-STRAP_W:0] DEV_CODE = 5'b10100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               sdaBit,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               busy,
  output strobe_t            strb,
  output logic               wrCommit,
  output logic               ctlIdle,
  output logic               devPhase
);

  ctlState_t  state, stNext;
  logic [3:0] bitCnt, cntNext;
  logic       isRead, rdNext;
  logic       wrPending, pendNext;
  logic       commitNext;
  logic       devMatch;

  assign devMatch = (rxByte[7:STRAP_W+1] == DEV_CODE) &&
                    (rxByte[STRAP_W:1] == strapAddr) && !busy;

  always_comb begin
    strb       = '0;
    stNext     = state;
    cntNext    = bitCnt;
    rdNext     = isRead;
    pendNext   = wrPending;
    commitNext = 1'b0;
    if (startDet) begin
      stNext       = ST_DEV;
      cntNext      = 4'd0;
      strb.sdaFree = 1'b1;
      pendNext     = 1'b0;
    end else if (stopDet) begin
      stNext       = ST_IDLE;
      cntNext      = 4'd0;
      strb.sdaFree = 1'b1;
      commitNext   = wrPending;
      pendNext     = 1'b0;
    end else if (state == ST_SEND) begin
      if (sclRise) begin
        if (bitCnt == 4'd8) begin
          // master acknowledge slot: high means no more bytes wanted
          if (sdaBit) begin
            stNext  = ST_IDLE;
            cntNext = 4'd0;
          end else begin
            cntNext = 4'd9;
          end
        end else begin
          cntNext = bitCnt + 4'd1;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          strb.sdaFree = 1'b1;
        end else if (bitCnt == 4'd9) begin
          strb.loadTx = 1'b1;
          cntNext     = 4'd0;
        end else if (bitCnt != 4'd0) begin
          strb.shiftTx = 1'b1;
        end
      end
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          strb.sampleBit = 1'b1;
          cntNext        = bitCnt + 4'd1;
        end else if (bitCnt == 4'd8) begin
          cntNext = 4'd9;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          unique case (state)
            ST_DEV: begin
              if (devMatch) begin
                strb.ackDrive = 1'b1;
                rdNext        = rxByte[0];
              end else begin
                stNext  = ST_IDLE;
                cntNext = 4'd0;
              end
            end
            ST_WHI: begin
              strb.ackDrive  = 1'b1;
              strb.setAddrHi = 1'b1;
            end
            ST_WLO: begin
              strb.ackDrive  = 1'b1;
              strb.setAddrLo = 1'b1;
            end
            default: begin
              strb.ackDrive  = 1'b1;
              strb.writeByte = 1'b1;
              pendNext       = 1'b1;
            end
          endcase
        end else if (bitCnt == 4'd9) begin
          cntNext = 4'd0;
          if (state == ST_DEV && isRead) begin
            stNext      = ST_SEND;
            strb.loadTx = 1'b1;
          end else begin
            strb.sdaFree = 1'b1;
            unique case (state)
              ST_DEV:  stNext = ST_WHI;
              ST_WHI:  stNext = ST_WLO;
              default: stNext = ST_WDAT;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= 4'd0;
      isRead    <= 1'b0;
      wrPending <= 1'b0;
      wrCommit  <= 1'b0;
    end else begin
      state     <= stNext;
      bitCnt    <= cntNext;
      isRead    <= rdNext;
      wrPending <= pendNext;
      wrCommit  <= commitNext;
    end
  end

  assign ctlIdle  = (state == ST_IDLE);
  assign devPhase = (state == ST_DEV);

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              sdaBit,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdReq,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam int HI_W = ADDR_W - 8;

  logic [7:0]        rxShift;
  logic [6:0]        txShift;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      ptr      <= '0;
      sdaOe    <= 1'b0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (strb.sampleBit) rxShift <= {rxShift[6:0], sdaBit};
      // SDA enable: transmit requests win over acknowledge and release
      if (strb.loadTx) begin
        txShift <= rdData[6:0];
        sdaOe   <= ~rdData[7];
        ptr     <= ptr + ADDR_W'(1);
      end else if (strb.shiftTx) begin
        txShift <= {txShift[5:0], 1'b0};
        sdaOe   <= ~txShift[6];
      end else if (strb.ackDrive) begin
        sdaOe <= 1'b1;
      end else if (strb.sdaFree) begin
        sdaOe <= 1'b0;
      end
      if (strb.setAddrHi) ptr[ADDR_W-1:8] <= rxShift[HI_W-1:0];
      if (strb.setAddrLo) ptr[7:0] <= rxShift;
      if (strb.writeByte) begin
        wrStrobe          <= 1'b1;
        wrAddr            <= ptr;
        wrData            <= rxShift;
        ptr[PAGE_W-1:0]   <= ptr[PAGE_W-1:0] + PAGE_W'(1);
      end
    end
  end

  assign rxByte = rxShift;
  assign rdAddr = ptr;
  assign rdReq  = strb.loadTx;

endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int                 ADDR_W      = 14,
  parameter int                 PAGE_W      = 6,
  parameter int                 STRAP_W     = 2,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [6-STRAP_W:0] DEV_CODE    = 5'b10100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               busy,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic               rdReq,
  input  logic [7:0]         rdData,
  output logic               wrStrobe,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [7:0]         wrData,
  output logic               wrCommit
);

  logic       sclRiseDet;
  logic       sclFallDet;
  logic       startDet;
  logic       stopDet;
  logic       sdaBit;
  logic [7:0] rxByte;
  logic       ctlIdle;
  logic       devPhase;
  strobe_t    strb;

  tws_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclRise  (sclRiseDet),
    .sclFall  (sclFallDet),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaBit   (sdaBit)
  );

  tws_control #(.STRAP_W(STRAP_W), .DEV_CODE(DEV_CODE)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .sclRise   (sclRiseDet),
    .sclFall   (sclFallDet),
    .startDet  (startDet),
    .stopDet   (stopDet),
    .sdaBit    (sdaBit),
    .rxByte    (rxByte),
    .strapAddr (strapAddr),
    .busy      (busy),
    .strb      (strb),
    .wrCommit  (wrCommit),
    .ctlIdle   (ctlIdle),
    .devPhase  (devPhase)
  );

  tws_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdaBit   (sdaBit),
    .rdData   (rdData),
    .rxByte   (rxByte),
    .sdaOe    (sdaOe),
    .rdAddr   (rdAddr),
    .rdReq    (rdReq),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker (
  input logic clk,
  input logic rstN,
  input logic sclFallDet,
  input logic startDet,
  input logic stopDet,
  input logic sdaOe,
  input logic busy,
  input logic devPhase,
  input logic ctlIdle,
  input logic wrStrobe,
  input logic rdReq,
  input logic wrCommit
);

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFallDet) || $past(startDet) || $past(stopDet))); // R14

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    ctlIdle |-> !sdaOe); // R13

  AST_START_FREES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe); // R2

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && devPhase) |-> !$past(busy)); // R12

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(stopDet)); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStrobe, rdReq, wrCommit})); // R5

endmodule

bind tws_eeprom_slave tws_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclFallDet (sclFallDet),
  .startDet   (startDet),
  .stopDet    (stopDet),
  .sdaOe      (sdaOe),
  .busy       (busy),
  .devPhase   (devPhase),
  .ctlIdle    (ctlIdle),
  .wrStrobe   (wrStrobe),
  .rdReq      (rdReq),
  .wrCommit   (wrCommit)
);

// File: tb/tb_tws_eeprom_slave.sv
module tb_tws_eeprom_slave;

  localparam int AW = 14;
  localparam int Q  = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          scl = 1'b1;
  logic          mSda = 1'b1;
  logic [1:0]    strap = 2'b00;
  logic          busy;
  logic          sdaOe;
  logic          rdReq;
  logic          wrStrobe;
  logic          wrCommit;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] wrAddr;
  logic [7:0]    rdData;
  logic [7:0]    wrData;
  wire           sdaLine = mSda & ~sdaOe;

  int nVec = 0;
  int nFail = 0;
  int nWr = 0;
  int nCommit = 0;
  int busyTimer = 0;
  logic [AW-1:0] logA [0:127];
  logic [7:0]    logD [0:127];

  always #10 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return a[7:0] ^ {2'b00, a[AW-1:8]} ^ 8'h5A;
  endfunction

  assign rdData = memByte(rdAddr);
  assign busy   = (busyTimer != 0);

  tws_eeprom_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAddr(strap), .busy(busy), .rdAddr(rdAddr), .rdReq(rdReq),
    .rdData(rdData), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .wrCommit(wrCommit)
  );

  // page buffer log and write-cycle model
  always @(negedge clk) begin
    if (wrStrobe && nWr < 128) begin
      logA[nWr] = wrAddr;
      logD[nWr] = wrData;
    end
    if (wrStrobe) nWr++;
    if (wrCommit) begin
      nCommit++;
      busyTimer = 400;
    end else if (busyTimer > 0) begin
      busyTimer--;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input logic b, output logic seen, output logic steady);
    mSda = b;
    waitQ();
    scl = 1'b1;
    waitQ();
    seen = sdaLine;
    waitQ();
    steady = (sdaLine == seen);
    scl = 1'b0;
    waitQ();
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s, st;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s, st);
    bitCycle(1'b1, s, st);
    ack = ~s;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic mAck);
    logic s, st;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s, st);
      b[i] = s;
      chk(st, "R14 output bit steady through SCL high", int'(st), 1);
    end
    bitCycle(~mAck, s, st);
  endtask

  function automatic logic [7:0] devByte(input logic [1:0] a, input logic rd);
    return {5'b10100, a, rd};
  endfunction

  task automatic setPointer(input logic [7:0] hi, input logic [7:0] lo);
    logic ack;
    startCond();
    sendByte(devByte(strap, 1'b0), ack);
    chk(ack, "R4 device byte acknowledged", int'(ack), 1);
    sendByte(hi, ack);
    chk(ack, "R4 high address acknowledged", int'(ack), 1);
    sendByte(lo, ack);
    chk(ack, "R4 low address acknowledged", int'(ack), 1);
  endtask

  task automatic waitIdleMem();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (R1..R14 run): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    logic ack, s, st;
    logic [7:0] b;
    int wrBase, comBase;
    logic [AW-1:0] base;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(sdaOe == 1'b0, "R1 SDA released after reset", int'(sdaOe), 0);
    chk(wrStrobe == 1'b0 && wrCommit == 1'b0, "R1 no strobes after reset",
        int'({wrStrobe, wrCommit}), 0);

    // R3 / R13: every strap against every address field
    for (int sv = 0; sv < 4; sv++) begin
      strap = 2'(sv);
      for (int av = 0; av < 4; av++) begin
        startCond();
        sendByte(devByte(2'(av), 1'b0), ack);
        chk(ack == (av == sv), "R3 address compare", int'(ack), int'(av == sv));
        if (av != sv) begin
          sendByte(8'h00, ack);
          chk(!ack, "R13 bytes ignored after mismatch", int'(ack), 0);
          chk(sdaOe == 1'b0, "R13 SDA released after mismatch", int'(sdaOe), 0);
        end
        stopCond();
      end
    end
    strap = 2'b10;
    startCond();
    sendByte(8'b1011_1000, ack);
    chk(!ack, "R3 wrong fixed code rejected", int'(ack), 0);
    stopCond();
    chk(nWr == 0 && nCommit == 0, "R13 no writes from rejected headers", nWr + nCommit, 0);

    // R5 byte write with ignored high bits, R7 commit, R12 polling
    setPointer(8'hC1, 8'h23);
    sendByte(8'hA5, ack);
    chk(ack, "R4 data byte acknowledged", int'(ack), 1);
    stopCond();
    chk(nWr == 1, "R5 one strobe per data byte", nWr, 1);
    chk(logA[0] == 14'h0123, "R5 write address, top bits ignored", int'(logA[0]), 'h0123);
    chk(logD[0] == 8'hA5, "R5 write data", int'(logD[0]), 'hA5);
    chk(nCommit == 1, "R7 commit after stop", nCommit, 1);
    startCond();
    sendByte(devByte(strap, 1'b0), ack);
    chk(!ack, "R12 NACK while busy", int'(ack), 0);
    stopCond();
    chk(nCommit == 1, "R7 header alone does not commit", nCommit, 1);
    waitIdleMem();
    startCond();
    sendByte(devByte(strap, 1'b0), ack);
    chk(ack, "R12 ACK once write cycle ends", int'(ack), 1);
    stopCond();

    // R9 current read after a write
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    chk(ack, "R4 read header acknowledged", int'(ack), 1);
    recvByte(b, 1'b0);
    chk(b == memByte(14'h0124), "R9 current read follows write", int'(b), int'(memByte(14'h0124)));
    stopCond();

    // R8 random read
    setPointer(8'h12, 8'h34);
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    chk(ack, "R8 read after repeated start acknowledged", int'(ack), 1);
    recvByte(b, 1'b0);
    chk(b == memByte(14'h1234), "R8 random read data", int'(b), int'(memByte(14'h1234)));
    stopCond();

    // R10 sequential read across the top of the array, R11 NACK end
    setPointer(8'hFF, 8'hFD);
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    for (int k = 0; k < 5; k++) begin
      logic [AW-1:0] ea;
      ea = AW'(14'h3FFD + k);
      recvByte(b, k < 4);
      chk(b == memByte(ea), "R10 sequential data with wrap", int'(b), int'(memByte(ea)));
    end
    for (int k = 0; k < 9; k++) begin
      bitCycle(1'b1, s, st);
      chk(s == 1'b1, "R11 SDA released after master NACK", int'(s), 1);
    end
    stopCond();
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    recvByte(b, 1'b0);
    chk(b == memByte(14'h0002), "R9 pointer after sequential read", int'(b), int'(memByte(14'h0002)));
    stopCond();

    // R6 page write past the page end
    base = 14'h153C;
    wrBase = nWr;
    comBase = nCommit;
    setPointer({2'b00, base[13:8]}, base[7:0]);
    for (int k = 0; k < 70; k++) begin
      sendByte(8'(k * 7 + 3), ack);
      chk(ack, "R4 page data acknowledged", int'(ack), 1);
    end
    stopCond();
    chk(nWr - wrBase == 70, "R6 strobe count", nWr - wrBase, 70);
    for (int k = 0; k < 70; k++) begin
      logic [AW-1:0] ea;
      ea = {base[13:6], 6'(base[5:0] + 6'(k))};
      chk(logA[wrBase + k] == ea, "R6 in-page address wrap", int'(logA[wrBase + k]), int'(ea));
      chk(logD[wrBase + k] == 8'(k * 7 + 3), "R6 page data", int'(logD[wrBase + k]), (k * 7 + 3) & 255);
    end
    chk(nCommit - comBase == 1, "R7 single commit for page", nCommit - comBase, 1);
    waitIdleMem();
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    recvByte(b, 1'b0);
    chk(b == memByte(14'h1502), "R9 pointer after page wrap", int'(b), int'(memByte(14'h1502)));
    stopCond();

    // R2 start in the middle of a data byte
    wrBase = nWr;
    setPointer(8'h00, 8'h40);
    for (int k = 0; k < 3; k++) bitCycle(1'b0, s, st);
    startCond();
    sendByte(devByte(strap, 1'b1), ack);
    chk(ack, "R2 fresh device byte after start", int'(ack), 1);
    recvByte(b, 1'b0);
    chk(b == memByte(14'h0040), "R2 pointer untouched by partial byte", int'(b), int'(memByte(14'h0040)));
    stopCond();
    chk(nWr == wrBase, "R2 partial byte not written", nWr - wrBase, 0);

    // R7 a start discards the pending commit
    comBase = nCommit;
    setPointer(8'h02, 8'h00);
    sendByte(8'h11, ack);
    startCond();
    stopCond();
    chk(nWr == wrBase + 1, "R5 accepted byte strobed", nWr - wrBase, 1);
    chk(nCommit == comBase, "R7 start discards commit", nCommit - comBase, 0);
    chk(sdaOe == 1'b0, "R2 SDA released at end", int'(sdaOe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule